// File: doc/BRIEF.md
# Timer PWM Output Generator

This block is an up-counting timer that drives one waveform pin. While its run input is high, the counter climbs to the all-ones value. At that point it raises an overflow event and restarts from a programmable reload value. When compare is enabled, it also raises a match event each time the count equals a compare value. A trigger-select field chooses which events act on the pin. A mode bit chooses whether each acting event inverts the pin (toggle) or drives a one-clock pulse (pulse).

A small state machine manages the pin. The states are IDLE, ARMED, ACTIVE, DRAIN and HALT.

- IDLE: the pin follows the idle-level input.
- IDLE to ARMED: taken when the timer runs with a non-zero trigger.
- ARMED: matches are ignored, so the first event that acts on the pin is always an overflow.
- ARMED to ACTIVE: taken on that first overflow.
- ACTIVE: every selected event acts on the pin.
- ACTIVE to DRAIN: taken when the trigger is cleared. DRAIN keeps modulating with the last trigger setting.
- ACTIVE or DRAIN to HALT: taken on the next overflow. That overflow still acts, and the pin then holds its level.
- HALT or DRAIN to ARMED: taken when the trigger becomes non-zero again.
- Any state to IDLE: taken when the run input falls.

A preset port writes the counter directly. Software can start at all-ones minus one so that an overflow comes first. Software must keep the reload and compare values at least 2 below all-ones. With both triggers selected, the compare value must exceed the reload value by at least 2.

Top module: `pwm_timer`

## Requirements
- R1: While run_en is high, the counter increases by 1 each clock. While run_en is low, it holds its value. When preset_we is high, count takes preset_val on the next clock, and this write has priority.
- R2: ovf_pulse is high in every cycle in which run_en is high and count is all-ones. The next count is load_val, so the overflow period is all-ones minus load_val plus 1 clocks.
- R3: match_pulse is high in every cycle in which run_en and cmp_en are high and count equals cmp_val.
- R4: trig_sel encoding is 0 = none, 1 = overflow only, 2 = overflow and match. In toggle mode (pulse_mode = 0), pwm_out inverts on the clock after each selected event.
- R5: After arming, any match before the first overflow leaves pwm_out unchanged. This holds in both modes.
- R6: In pulse mode (pulse_mode = 1), pwm_out shows the inverse of idle_level for exactly the one clock that follows each selected event. Otherwise it shows idle_level.
- R7: In IDLE (run_en low, or trigger 0 before modulation), pwm_out takes idle_level one clock later. While modulating in toggle mode, idle_level has no effect.
- R8: When trig_sel is cleared during modulation, events keep acting up to and including the next overflow. After that, pwm_out holds its level and ignores idle_level.
- R9: The gate of R5 is re-armed on every start of the timer and whenever trig_sel goes from 0 to non-zero.
- R10: After reset, count is 0, pwm_out is 0 and the state is IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Counter runs while high |
| load_val | input | W | Reload value after overflow |
| cmp_val | input | W | Compare value |
| cmp_en | input | 1 | Enables match events |
| trig_sel | input | 2 | Events acting on the pin |
| pulse_mode | input | 1 | 1 = pulse, 0 = toggle |
| idle_level | input | 1 | Pin level when idle; pulse base level |
| preset_we | input | 1 | Writes preset_val into the counter |
| preset_val | input | W | Counter preset value |
| pwm_out | output | 1 | Waveform pin |
| ovf_pulse | output | 1 | Overflow event |
| match_pulse | output | 1 | Match event |
| count | output | W | Current counter value |

## Verification
A wrong state appears at pwm_out within one clock of the first event it mishandles. For example, a machine that leaves ARMED too early inverts the pin one clock after an early match. A machine that skips DRAIN freezes the pin one overflow period too soon. The bench therefore compares the pin in every cycle against an event parity computed arithmetically from the counter phase. A lost gate or a missed halt then fails on the very next clock.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARMED  = 3'd1,
        ST_ACTIVE = 3'd2,
        ST_DRAIN  = 3'd3,
        ST_HALT   = 3'd4
    } mod_state_t;

    localparam logic [1:0] TRIG_OFF  = 2'd0;
    localparam logic [1:0] TRIG_OVF  = 2'd1;
    localparam logic [1:0] TRIG_BOTH = 2'd2;
endpackage

// File: rtl/pwm_tick_counter.sv
module pwm_tick_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] cmp_val,
    input  logic         cmp_en,
    input  logic         preset_we,
    input  logic [W-1:0] preset_val,
    output logic [W-1:0] cnt,
    output logic         ovf_evt,
    output logic         match_evt
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (preset_we) begin
            cnt <= preset_val;
        end else if (run_en) begin
            cnt <= (cnt == TOP) ? load_val : cnt + 1'b1;
        end
    end

    assign ovf_evt   = run_en && (cnt == TOP);
    assign match_evt = run_en && cmp_en && (cnt == cmp_val);

    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !preset_we) |=> $stable(cnt));

    // R2
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !preset_we) |=> (cnt == $past(load_val)));

    // R2
    no_double_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !preset_we && load_val != TOP) |=> !ovf_evt);
endmodule

// File: rtl/pwm_mod_fsm.sv
module pwm_mod_fsm
    import pwm_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic [1:0] trig_sel,
    input  logic       pulse_mode,
    input  logic       idle_level,
    input  logic       ovf_evt,
    input  logic       match_evt,
    output logic       pwm_out
);
    mod_state_t st, nxt;
    logic [1:0] trig_q;
    logic       fire;
    logic       trig_on;

    assign trig_on = (trig_sel != TRIG_OFF);

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:   if (run_en && trig_on) nxt = ST_ARMED;
            ST_ARMED: begin
                if (!run_en || !trig_on) nxt = ST_IDLE;
                else if (ovf_evt)        nxt = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (!run_en)       nxt = ST_IDLE;
                else if (!trig_on) nxt = ovf_evt ? ST_HALT : ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!run_en)      nxt = ST_IDLE;
                else if (trig_on) nxt = ST_ARMED;
                else if (ovf_evt) nxt = ST_HALT;
            end
            ST_HALT: begin
                if (!run_en)      nxt = ST_IDLE;
                else if (trig_on) nxt = ST_ARMED;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (st)
            ST_ARMED:           fire = run_en && trig_on && ovf_evt;
            ST_ACTIVE, ST_DRAIN: fire = run_en &&
                                  (ovf_evt || (match_evt && trig_q == TRIG_BOTH));
            default:            fire = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_out <= 1'b0;
            trig_q  <= TRIG_OFF;
        end else begin
            if (st == ST_IDLE)  pwm_out <= idle_level;
            else if (!run_en)   pwm_out <= pwm_out;
            else if (fire)      pwm_out <= pulse_mode ? ~idle_level : ~pwm_out;
            else if (pulse_mode) pwm_out <= idle_level;
            if ((st == ST_ARMED || st == ST_ACTIVE) && trig_on)
                trig_q <= trig_sel;
        end
    end

    // R5
    early_match_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARMED && run_en && trig_on && !ovf_evt && !pulse_mode)
        |=> $stable(pwm_out));

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALT && run_en && !trig_on && !pulse_mode) |=> $stable(pwm_out));

    // R7
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |=> (pwm_out == $past(idle_level)));

    // R6
    pulse_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACTIVE && run_en && pulse_mode && !ovf_evt && !match_evt)
        |=> (pwm_out == $past(idle_level)));
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] cmp_val,
    input  logic         cmp_en,
    input  logic [1:0]   trig_sel,
    input  logic         pulse_mode,
    input  logic         idle_level,
    input  logic         preset_we,
    input  logic [W-1:0] preset_val,
    output logic         pwm_out,
    output logic         ovf_pulse,
    output logic         match_pulse,
    output logic [W-1:0] count
);
    logic ovf_w, match_w;

    pwm_tick_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .load_val(load_val), .cmp_val(cmp_val), .cmp_en(cmp_en),
        .preset_we(preset_we), .preset_val(preset_val),
        .cnt(count), .ovf_evt(ovf_w), .match_evt(match_w)
    );

    pwm_mod_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .trig_sel(trig_sel),
        .pulse_mode(pulse_mode), .idle_level(idle_level),
        .ovf_evt(ovf_w), .match_evt(match_w), .pwm_out(pwm_out)
    );

    assign ovf_pulse   = ovf_w;
    assign match_pulse = match_w;
endmodule

// File: tb/tb_pwm_timer.sv
module tb_pwm_timer;
    localparam int PER = 10;
    localparam logic [31:0] TOP = 32'hFFFF_FFFF;

    logic clk = 0, rst_n = 0, run_en = 0, cmp_en = 0, pulse_mode = 0;
    logic idle_level = 0, preset_we = 0;
    logic [1:0] trig_sel = 0;
    logic [31:0] load_val = 0, cmp_val = 0, preset_val = 0;
    logic pwm_out, ovf_pulse, match_pulse;
    logic [31:0] count;
    int total = 0, bad = 0;

    always #(PER/2) clk = ~clk;

    pwm_timer dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .load_val(load_val),
        .cmp_val(cmp_val), .cmp_en(cmp_en), .trig_sel(trig_sel),
        .pulse_mode(pulse_mode), .idle_level(idle_level),
        .preset_we(preset_we), .preset_val(preset_val),
        .pwm_out(pwm_out), .ovf_pulse(ovf_pulse),
        .match_pulse(match_pulse), .count(count)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // One run: arithmetic expectation from the counter phase.
    task automatic run_case(input int P, input int d, input bit L, input int trig,
                            input bit pulse, input bit from_load, input int clear_at,
                            input int flip_at, input int n, input string tag);
        logic [31:0] ld;
        int p0;
        bit seen, halted, pin_e, act;
        ld = TOP - 32'(P) + 1;
        @(negedge clk);
        run_en = 0; trig_sel = 2'(trig); pulse_mode = pulse; idle_level = L;
        cmp_en = 1; load_val = ld; cmp_val = ld + 32'(d);
        preset_we = 1; preset_val = from_load ? ld : TOP - 1;
        @(negedge clk);
        preset_we = 0;
        @(negedge clk);
        run_en = 1;
        p0 = from_load ? 0 : P - 2;
        seen = 0; halted = 0; pin_e = L;
        for (int k = 0; k < n; k++) begin
            int ph;
            bit e_ovf, e_m;
            ph = (p0 + k) % P;
            e_ovf = (ph == P - 1);
            e_m = (ph == d);
            if (k == clear_at) trig_sel = 2'd0;
            if (k == flip_at) idle_level = ~idle_level;
            #1;
            chk(count == ld + 32'(ph), "R1", "count", count, ld + 32'(ph));
            chk(ovf_pulse == e_ovf, "R2", "ovf_pulse", ovf_pulse, e_ovf);
            chk(match_pulse == e_m, "R3", "match_pulse", match_pulse, e_m);
            chk(pwm_out == pin_e, tag, "pwm_out", pwm_out, pin_e);
            if (k == 0 || halted) act = 0;
            else if (!seen) act = e_ovf;
            else act = e_ovf || (e_m && trig == 2);
            if (clear_at >= 0 && k >= clear_at && seen && e_ovf) halted = 1;
            if (k > 0 && e_ovf) seen = 1;
            pin_e = pulse ? (act ? ~idle_level : idle_level) : (pin_e ^ act);
            @(negedge clk);
        end
    endtask

    initial begin
        #(PER * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (2) @(negedge clk);
        #1;
        // R10 reset state
        chk(count == 0, "R10", "count", count, 0);
        chk(pwm_out == 0, "R10", "pwm_out", pwm_out, 0);
        chk(ovf_pulse == 0, "R10", "ovf_pulse", ovf_pulse, 0);
        rst_n = 1;
        // Sweep R4 toggle and R6 pulse over periods, compare offsets, levels, triggers
        for (int P = 5; P <= 8; P++)
            for (int d = 2; d <= P - 3; d++)
                for (int L = 0; L < 2; L++)
                    for (int t = 1; t <= 2; t++)
                        for (int m = 0; m < 2; m++)
                            run_case(P, d, L[0], t, m[0], 0, -1, -1, 3 * P + 3,
                                     m ? "R6" : "R4");
        // R5 / R9: restart from the reload value, early match must be ignored
        run_case(8, 3, 0, 2, 0, 1, -1, -1, 28, "R5/R9");
        run_case(8, 3, 1, 2, 1, 1, -1, -1, 28, "R5/R9");
        // R8: clear trigger mid-modulation; idle_level flipped after halt
        run_case(6, 2, 0, 2, 0, 0, 5, 16, 26, "R8");
        run_case(7, 3, 1, 1, 0, 0, 10, 20, 28, "R8");
        // R7: idle_level flipped while modulating in toggle mode
        run_case(5, 2, 0, 1, 0, 0, -1, 3, 18, "R7");
        // R1 hold while stopped, R7 pin returns to idle_level
        @(negedge clk);
        run_en = 0; idle_level = 1;
        #1 held = count;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            chk(count == held, "R1", "count hold", count, held);
        end
        chk(pwm_out == 1'b1, "R7", "idle pwm_out", pwm_out, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule